// File: doc/BRIEF.md
# Prioritized Interrupt Type Responder

This peripheral-side block watches eight active-low interrupt request lines and raises a single maskable request toward the processor. The processor answers with two active-low acknowledge pulses. The first pulse only opens the acknowledge cycle. At that moment the block latches the number of the highest-priority active line and drops its request. During the second pulse the block enables its bus outputs and presents an 8-bit interrupt type byte. At every other time the enable is low, so the shared data bus stays free for other traffic.

The type byte is formed from a fixed base. The latched line number is inverted and placed in a three-bit field. With the default base, line 2 yields 0xD0. Because the line number is latched on the first pulse, request lines that change later in the handshake do not alter the byte. All logic is synchronous to one clock with a synchronous active-low reset. Acknowledge edges are detected by comparing the acknowledge input with its value one cycle earlier.

Top module: `irq_type_responder`

## Requirements
- R1: In the cycle after a clock edge that samples `rstN` low, `intReq`, `busEn` and `busData` are all 0.
- R2: When no handshake is open and any `reqN` bit is sampled low at a clock edge, `intReq` is 1 after that edge.
- R3: `intReq` goes to 0 at the edge that samples the first falling edge of `ackN`, and it stays 0 until the handshake ends.
- R4: Line 7 has the highest priority and line 0 the lowest. The type byte has bit 7 = 1 and bits [3:0] = 0. Bits [6:4] hold the bitwise complement of the winning line number, so line 2 gives 0xD0, line 7 gives 0x80 and line 0 gives 0xF0.
- R5: `busEn` stays 0 during the first acknowledge pulse and during the gap that follows it.
- R6: `busEn` is 1 from the edge that samples the second `ackN` low until the edge that samples `ackN` high again.
- R7: The winning line is latched at the edge that samples the first `ackN` low. Request changes after that edge have no effect on the byte driven during the second pulse.
- R8: `busData` is 0 whenever `busEn` is 0, which releases the bus.
- R9: If no request is active when the first pulse is sampled, the second pulse leaves `busEn` at 0. The same applies to a later lone pulse pair that arrives with no request active.
- R10: At the edge that samples the end of the second pulse, the handshake closes. From that edge `intReq` again follows whether any request is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqN | input | 8 | Interrupt request lines, active low, bit 7 highest priority |
| ackN | input | 1 | Acknowledge strobe from the processor, active low |
| intReq | output | 1 | Maskable interrupt request to the processor |
| busData | output | 8 | Type byte to the data bus, 0 when released |
| busEn | output | 1 | Output enable for the bus drivers |

## Verification
Every result of this block is registered. `intReq`, `busEn` and the latched line number each change at the first clock edge that samples the causing change on `reqN` or `ackN`. `busData` follows `busEn` in the same cycle. The bench changes inputs on falling clock edges. A behavioural model advances on each rising edge and is compared with the ports 1 ns later, which is exactly one register stage after each stimulus. Named spot checks are taken while the second pulse is held low, after at least one rising edge has sampled it.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE   = 2'd0,
    ACK_FIRST  = 2'd1,
    ACK_SECOND = 2'd2
  } ackPhase_t;

  typedef struct packed {
    logic capture;
    logic drive;
  } ackStrobe_t;
endpackage

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ackN,
  input  logic       anyActive,
  output ackStrobe_t strobes,
  output logic       intReq
);
  ackPhase_t phase, phaseNext;
  logic ackPrevN;
  logic ackFall, ackRise;
  logic captureNow;

  assign ackFall = ackPrevN & ~ackN;
  assign ackRise = ~ackPrevN & ackN;

  always_comb begin
    phaseNext  = phase;
    captureNow = 1'b0;
    case (phase)
      ACK_IDLE: if (ackFall) begin
        phaseNext  = ACK_FIRST;
        captureNow = 1'b1;
      end
      ACK_FIRST:  if (ackFall) phaseNext = ACK_SECOND;
      ACK_SECOND: if (ackRise) phaseNext = ACK_IDLE;
      default:    phaseNext = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= ACK_IDLE;
      ackPrevN <= 1'b1;
      intReq   <= 1'b0;
    end else begin
      phase    <= phaseNext;
      ackPrevN <= ackN;
      intReq   <= anyActive && (phaseNext == ACK_IDLE);
    end
  end

  assign strobes.capture = captureNow;
  assign strobes.drive   = (phase == ACK_SECOND);

  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase != ACK_IDLE) |-> !intReq);

  // R6
  second_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ACK_SECOND) |=> (phase == ACK_SECOND || phase == ACK_IDLE));

  // R5
  drive_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.drive) |-> !$past(ackN));
endmodule

// File: rtl/irq_type_path.sv
module irq_type_path
  import irq_resp_pkg::*;
#(
  parameter int                NUM_REQ   = 8,
  parameter int                TYPE_W    = 8,
  parameter logic [TYPE_W-1:0] TYPE_BASE = 8'hA0,
  parameter int                IDX_LSB   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_REQ-1:0] reqN,
  input  ackStrobe_t        strobes,
  output logic              anyActive,
  output logic [TYPE_W-1:0] busData,
  output logic              busEn
);
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [NUM_REQ-1:0] activeVec;
  logic [IDX_W-1:0]   winIdx, capIdx;
  logic               capValid;
  logic [TYPE_W-1:0]  typeByte;

  assign activeVec = ~reqN;
  assign anyActive = |activeVec;

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (activeVec[i]) winIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capIdx   <= '0;
      capValid <= 1'b0;
    end else if (strobes.capture) begin
      capIdx   <= winIdx;
      capValid <= anyActive;
    end
  end

  always_comb begin
    typeByte = TYPE_BASE;
    for (int b = 0; b < IDX_W; b++) begin
      typeByte[IDX_LSB+b] = ~capIdx[b];
    end
  end

  assign busEn   = strobes.drive & capValid;
  assign busData = busEn ? typeByte : '0;

  // R7
  hold_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(capIdx));
endmodule

// File: rtl/irq_type_responder.sv
module irq_type_responder
  import irq_resp_pkg::*;
#(
  parameter int                NUM_REQ   = 8,
  parameter int                TYPE_W    = 8,
  parameter logic [TYPE_W-1:0] TYPE_BASE = 8'hA0,
  parameter int                IDX_LSB   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqN,
  input  logic               ackN,
  output logic               intReq,
  output logic [TYPE_W-1:0]  busData,
  output logic               busEn
);
  ackStrobe_t strobes;
  logic anyActive;

  irq_ack_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ackN      (ackN),
    .anyActive (anyActive),
    .strobes   (strobes),
    .intReq    (intReq)
  );

  irq_type_path #(
    .NUM_REQ   (NUM_REQ),
    .TYPE_W    (TYPE_W),
    .TYPE_BASE (TYPE_BASE),
    .IDX_LSB   (IDX_LSB)
  ) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .reqN      (reqN),
    .strobes   (strobes),
    .anyActive (anyActive),
    .busData   (busData),
    .busEn     (busEn)
  );

  // R8
  released_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |-> (busData == '0));
endmodule

// File: tb/test_irq_type_responder.sv
`timescale 1ns/1ps
module test_irq_type_responder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqN = 8'hFF;
  logic       ackN = 1'b1;
  logic       intReq;
  logic [7:0] busData;
  logic       busEn;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R1";

  // reference model state
  int mCnt = 0;
  int mIdx = 0;
  bit mValid = 0;
  bit mPrev = 1;
  bit mReq = 0;

  always #2 clk = ~clk;

  irq_type_responder i_irq_type_responder (
    .clk(clk), .rstN(rstN), .reqN(reqN), .ackN(ackN),
    .intReq(intReq), .busData(busData), .busEn(busEn)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    begin
      bit any;
      int hi;
      bit fall, rise;
      any = 0; hi = 0;
      for (int i = 0; i < 8; i++) if (reqN[i] == 1'b0) begin any = 1; hi = i; end
      if (!rstN) begin
        mCnt = 0; mIdx = 0; mValid = 0; mPrev = 1; mReq = 0;
      end else begin
        fall = mPrev && !ackN;
        rise = !mPrev && ackN;
        if (mCnt == 0 && fall) begin mCnt = 1; mValid = any; mIdx = hi; end
        else if (mCnt == 1 && fall) mCnt = 2;
        else if (mCnt == 2 && rise) mCnt = 0;
        mPrev = ackN;
        mReq = any && (mCnt == 0);
      end
    end
    #1;
    begin
      bit expEn;
      logic [7:0] expData;
      expEn = (mCnt == 2) && mValid;
      expData = expEn ? 8'(8'h80 | ((7 - mIdx) << 4)) : 8'h00;
      check({curReq, " intReq"}, {7'd0, intReq}, {7'd0, mReq});
      check({curReq, " busEn R5 R6"}, {7'd0, busEn}, {7'd0, expEn});
      check({curReq, " busData R4 R8"}, busData, expData);
    end
  end

  task automatic ackPulse(input int lowC, input int highC);
    ackN = 1'b0;
    repeat (lowC) @(negedge clk);
    ackN = 1'b1;
    repeat (highC) @(negedge clk);
  endtask

  // first pulse, then second pulse held low; spot check mid-pulse
  task automatic handshake(input string tag, input logic [7:0] expByte, input bit expDrive);
    ackPulse(2, 2);
    ackN = 1'b0;
    repeat (2) @(negedge clk);
    check({tag, " busEn"}, {7'd0, busEn}, {7'd0, expDrive});
    check({tag, " byte"}, busData, expDrive ? expByte : 8'h00);
    @(negedge clk);
    ackN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("R1 intReq", {7'd0, intReq}, 8'd0);
    check("R1 busEn", {7'd0, busEn}, 8'd0);
    check("R1 busData", busData, 8'h00);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    curReq = "R2";
    reqN[2] = 1'b0;
    @(negedge clk);
    check("R2 intReq raised", {7'd0, intReq}, 8'd1);

    curReq = "R3";
    ackN = 1'b0;
    @(negedge clk);
    check("R3 intReq dropped", {7'd0, intReq}, 8'd0);
    check("R5 first pulse idle", {7'd0, busEn}, 8'd0);
    ackN = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 gap idle", {7'd0, busEn}, 8'd0);
    curReq = "R6";
    ackN = 1'b0;
    @(negedge clk);
    check("R6 drive on", {7'd0, busEn}, 8'd1);
    check("R4 line2 D0", busData, 8'hD0);
    ackN = 1'b1;
    @(negedge clk);
    check("R6 drive off", {7'd0, busEn}, 8'd0);
    check("R10 intReq back", {7'd0, intReq}, 8'd1);
    reqN = 8'hFF;
    repeat (2) @(negedge clk);

    curReq = "R4";
    reqN = 8'h7E;           // lines 7 and 0
    @(negedge clk);
    handshake("R4 line7", 8'h80, 1'b1);
    reqN = 8'hFE;           // line 0 only
    @(negedge clk);
    handshake("R4 line0", 8'hF0, 1'b1);
    reqN = 8'hFF;
    @(negedge clk);

    curReq = "R7";
    reqN[5] = 1'b0;
    @(negedge clk);
    ackPulse(1, 1);
    reqN = 8'h7F;           // line 7 only, after latch
    @(negedge clk);
    ackN = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 latched line5", busData, 8'hA0);
    ackN = 1'b1;
    repeat (2) @(negedge clk);
    reqN = 8'hFF;
    repeat (2) @(negedge clk);

    curReq = "R9";
    handshake("R9 no request", 8'h00, 1'b0);
    ackPulse(2, 2);         // lone pulse
    check("R9 lone pulse", {7'd0, busEn}, 8'd0);
    ackPulse(2, 2);
    check("R8 released", busData, 8'h00);

    curReq = "R10";
    reqN[3] = 1'b0;
    @(negedge clk);
    handshake("R10 line3", 8'hC0, 1'b1);
    check("R10 intReq resumes", {7'd0, intReq}, 8'd1);
    reqN = 8'hFF;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule